// File: doc/BRIEF.md
# Trigger-Selected Hit Packet Buffer

This block sits inside one pixel region and collects hit packets from several pixel unit cells. Each packet holds an arrival timestamp and a time-over-threshold value. A cell raises its valid line with a packet and keeps it up until the buffer acknowledges it. Accepted packets go into a bounded queue that keeps arrival order. Trigger matching plays no part in whether a packet is accepted.

When a trigger strobe arrives with a time tag, the buffer searches the stored packets. It releases the oldest packet whose timestamp equals the tag, and that packet leaves the queue. In the same step it discards every stored packet that has fallen too far behind the tag. Every trigger produces a one-cycle output strobe, and a hit flag tells whether a packet was found. A miss gives zeroed output fields, so downstream logic always sees a fresh result for each trigger decision.

Top module: `trig_hit_buffer`

## Requirements
- R1: While reset is applied and after it is released, `cell_ack`, `out_strobe`, `out_hit` and `full` are all low and the queue is empty.
- R2: A cell whose valid line is high while the queue is not full has its packet stored at the next clock edge. Its `cell_ack` bit is then high for exactly one cycle. This happens whether or not a trigger is present.
- R3: If several cells are valid in the same cycle, only the lowest-indexed one is accepted at that edge. The others follow at later edges in index order, and `cell_ack` carries at most one bit set.
- R4: `full` is high exactly when the queue holds DEPTH packets (default 8). No packet is accepted at an edge where `full` is high.
- R5: Every clock edge that samples `trig_valid` high produces `out_strobe` high for the following cycle only.
- R6: On a trigger, the oldest stored packet whose timestamp equals `trig_tag` is presented with `out_hit` high and is removed from the queue. Later packets with the same timestamp remain stored.
- R7: On a trigger that finds no equal timestamp, `out_hit` is low and `out_toa` and `out_tot` are zero.
- R8: On a trigger, a stored packet is discarded when its age, (`trig_tag` − timestamp) mod 256, is greater than WINDOW (default 16) and below 128. An age of exactly WINDOW is kept, as is an age of 128 or more, which counts as a packet ahead of the tag. The survivors keep their arrival order.
- R9: A packet accepted at the same edge as a trigger is not searched by that trigger. It is stored behind the surviving packets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cell_valid | input | NUM_CELLS | Per-cell packet present |
| cell_toa | input | NUM_CELLS×8 | Per-cell arrival timestamp |
| cell_tot | input | NUM_CELLS×4 | Per-cell time-over-threshold value |
| trig_valid | input | 1 | Trigger strobe |
| trig_tag | input | 8 | Trigger time tag |
| cell_ack | output | NUM_CELLS | Per-cell acknowledge, one-cycle pulse |
| out_strobe | output | 1 | One cycle after each trigger decision |
| out_hit | output | 1 | Decision found a matching packet |
| out_toa | output | 8 | Released timestamp, zero on a miss |
| out_tot | output | 4 | Released time-over-threshold, zero on a miss |
| full | output | 1 | Queue holds DEPTH packets |

## Verification
Acceptance of a cell packet and evaluation of a trigger can land on the same clock edge. That edge also removes the matched entry and the stale ones. The bench provokes this by raising a cell's valid line and the trigger strobe at the same falling edge, with the incoming timestamp equal to the trigger tag and three stored packets already past the window. It judges the outcome from the ports. The trigger must report a miss while the cell is still acknowledged, and a later trigger with the same tag must release the new packet. A further trigger probes one of the discarded timestamps and must miss, and a packet sitting exactly at the window edge must still be found.

// File: rtl/tpb_pkg.sv
package tpb_pkg;

  localparam int unsigned HIT_TOA_W = 8;
  localparam int unsigned HIT_TOT_W = 4;

  typedef struct packed {
    logic [HIT_TOA_W-1:0] toa;
    logic [HIT_TOT_W-1:0] tot;
  } hit_t;

  // Age of a stored timestamp relative to a trigger tag, modulo the tag range.
  // Ages in the upper half are treated as "ahead of the tag" and never stale.
  function automatic logic is_stale(input logic [HIT_TOA_W-1:0] tag,
                                    input logic [HIT_TOA_W-1:0] toa,
                                    input logic [HIT_TOA_W-1:0] window);
    logic [HIT_TOA_W-1:0] age;
    age = tag - toa;
    return (!age[HIT_TOA_W-1]) && (age > window);
  endfunction

endpackage

// File: rtl/tpb_cell_arb.sv
module tpb_cell_arb #(
  parameter int unsigned NUM_CELLS = 4
) (
  input  logic [NUM_CELLS-1:0] req,
  output logic [NUM_CELLS-1:0] grant,
  output logic                 any_grant
);

  always_comb begin
    grant     = '0;
    any_grant = 1'b0;
    for (int i = 0; i < NUM_CELLS; i++) begin
      if (req[i] && !any_grant) begin
        grant[i]  = 1'b1;
        any_grant = 1'b1;
      end
    end
  end

endmodule

// File: rtl/tpb_trig_match.sv
module tpb_trig_match
  import tpb_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned WINDOW = 16
) (
  input  hit_t [DEPTH-1:0]       ent,
  input  logic [DEPTH-1:0]       ent_vld,
  input  logic                   trig_valid,
  input  logic [HIT_TOA_W-1:0]   trig_tag,
  output logic                   found,
  output hit_t                   sel_hit,
  output logic [DEPTH-1:0]       drop
);

  localparam logic [HIT_TOA_W-1:0] WIN_L = HIT_TOA_W'(WINDOW);

  logic [DEPTH-1:0] sel;
  logic [DEPTH-1:0] stale;

  // Scan from the newest slot down so that the oldest match wins.
  always_comb begin
    sel     = '0;
    found   = 1'b0;
    sel_hit = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (ent_vld[i] && (ent[i].toa == trig_tag)) begin
        sel     = '0;
        sel[i]  = 1'b1;
        found   = 1'b1;
        sel_hit = ent[i];
      end
    end
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      stale[i] = ent_vld[i] && is_stale(trig_tag, ent[i].toa, WIN_L);
    end
    drop = trig_valid ? (sel | stale) : '0;
  end

  // R6: a reported match really carries the requested timestamp
  always_comb begin
    if (found) begin
      a_r6_match_tag: assert (sel_hit.toa == trig_tag);
    end
  end

endmodule

// File: rtl/tpb_hit_queue.sv
module tpb_hit_queue
  import tpb_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   push,
  input  hit_t                   push_hit,
  input  logic [DEPTH-1:0]       drop,
  output hit_t [DEPTH-1:0]       ent,
  output logic [DEPTH-1:0]       ent_vld,
  output logic [CNT_W-1:0]       count
);

  hit_t [DEPTH-1:0] ent_q, ent_nxt;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             upd;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      ent_vld[i] = (CNT_W'(i) < cnt_q);
    end
  end

  // Compact the surviving entries towards slot 0, then append the new one.
  always_comb begin
    int n;
    n       = 0;
    ent_nxt = ent_q;
    for (int i = 0; i < DEPTH; i++) begin
      if (ent_vld[i] && !drop[i]) begin
        ent_nxt[n] = ent_q[i];
        n          = n + 1;
      end
    end
    if (push && (n < DEPTH)) begin
      ent_nxt[n] = push_hit;
      n          = n + 1;
    end
    cnt_nxt = CNT_W'(n);
    upd     = push || (|(drop & ent_vld));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (upd) begin
      ent_q <= ent_nxt;
    end
  end

  assign ent   = ent_q;
  assign count = cnt_q;

  // R4: occupancy never exceeds the queue depth
  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));

  // R2: a push never shrinks the queue unless a trigger dropped entries
  a_r2_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (push && (drop == '0) && (cnt_q < CNT_W'(DEPTH))) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/trig_hit_buffer.sv
module trig_hit_buffer
  import tpb_pkg::*;
#(
  parameter int unsigned NUM_CELLS = 4,
  parameter int unsigned DEPTH     = 8,
  parameter int unsigned WINDOW    = 16
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [NUM_CELLS-1:0]                 cell_valid,
  input  logic [NUM_CELLS-1:0][HIT_TOA_W-1:0]  cell_toa,
  input  logic [NUM_CELLS-1:0][HIT_TOT_W-1:0]  cell_tot,
  input  logic                                 trig_valid,
  input  logic [HIT_TOA_W-1:0]                 trig_tag,
  output logic [NUM_CELLS-1:0]                 cell_ack,
  output logic                                 out_strobe,
  output logic                                 out_hit,
  output logic [HIT_TOA_W-1:0]                 out_toa,
  output logic [HIT_TOT_W-1:0]                 out_tot,
  output logic                                 full
);

  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  // Reset: asserted asynchronously, released through two flops
  logic rst_s1, rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_ns <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_ns <= rst_s1;
    end
  end

  // Acceptance path
  logic [NUM_CELLS-1:0] ack_q, grant, arb_req;
  logic                 any_grant;
  hit_t                 push_hit;
  logic [CNT_W-1:0]     count;
  logic                 full_w;

  assign full_w  = (count == CNT_W'(DEPTH));
  assign arb_req = cell_valid & ~ack_q & {NUM_CELLS{~full_w}};

  tpb_cell_arb #(.NUM_CELLS(NUM_CELLS)) u_arb (
    .req       (arb_req),
    .grant     (grant),
    .any_grant (any_grant)
  );

  always_comb begin
    push_hit = '0;
    for (int i = 0; i < NUM_CELLS; i++) begin
      if (grant[i]) begin
        push_hit.toa = push_hit.toa | cell_toa[i];
        push_hit.tot = push_hit.tot | cell_tot[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      ack_q <= '0;
    end else begin
      ack_q <= grant;
    end
  end

  // Storage and trigger evaluation
  hit_t [DEPTH-1:0] ent;
  logic [DEPTH-1:0] ent_vld, drop;
  logic             found;
  hit_t             sel_hit;

  tpb_hit_queue #(.DEPTH(DEPTH)) u_queue (
    .clk      (clk),
    .rst_n    (rst_ns),
    .push     (any_grant),
    .push_hit (push_hit),
    .drop     (drop),
    .ent      (ent),
    .ent_vld  (ent_vld),
    .count    (count)
  );

  tpb_trig_match #(.DEPTH(DEPTH), .WINDOW(WINDOW)) u_match (
    .ent        (ent),
    .ent_vld    (ent_vld),
    .trig_valid (trig_valid),
    .trig_tag   (trig_tag),
    .found      (found),
    .sel_hit    (sel_hit),
    .drop       (drop)
  );

  // Match register: every decision refreshes the output
  logic strobe_q, hit_q;
  hit_t out_q, out_nxt;

  assign out_nxt = found ? sel_hit : '0;

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      strobe_q <= 1'b0;
      hit_q    <= 1'b0;
    end else begin
      strobe_q <= trig_valid;
      if (trig_valid) begin
        hit_q <= found;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (trig_valid) begin
      out_q <= out_nxt;
    end
  end

  assign cell_ack   = ack_q;
  assign out_strobe = strobe_q;
  assign out_hit    = hit_q;
  assign out_toa    = out_q.toa;
  assign out_tot    = out_q.tot;
  assign full       = full_w;

  // R3: at most one acknowledge at a time
  a_r3_ack_onehot: assert property (@(posedge clk) disable iff (!rst_ns)
    $onehot0(ack_q));

  // R2: an acknowledge never repeats for the same cell on the next cycle
  a_r2_ack_pulse: assert property (@(posedge clk) disable iff (!rst_ns)
    (|ack_q) |=> ((ack_q & $past(ack_q)) == '0));

  // R4: nothing is accepted while the queue is full
  a_r4_no_ack_full: assert property (@(posedge clk) disable iff (!rst_ns)
    full_w |=> (ack_q == '0));

  // R5: one strobe per trigger, and none without one
  a_r5_strobe_follows: assert property (@(posedge clk) disable iff (!rst_ns)
    trig_valid |=> out_strobe);
  a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rst_ns)
    !trig_valid |=> !out_strobe);

  // R7: a miss presents zeroed fields
  a_r7_miss_zero: assert property (@(posedge clk) disable iff (!rst_ns)
    (out_strobe && !out_hit) |-> ((out_toa == '0) && (out_tot == '0)));

endmodule

// File: tb/trig_hit_buffer_tb.sv
`timescale 1ns/1ps
module trig_hit_buffer_tb;

  localparam int NC = 4;

  logic            clk;
  logic            rst_n;
  logic [NC-1:0]   cell_valid;
  logic [NC-1:0][7:0] cell_toa;
  logic [NC-1:0][3:0] cell_tot;
  logic            trig_valid;
  logic [7:0]      trig_tag;
  logic [NC-1:0]   cell_ack;
  logic            out_strobe, out_hit, full;
  logic [7:0]      out_toa;
  logic [3:0]      out_tot;

  int n_chk  = 0;
  int n_fail = 0;

  trig_hit_buffer #(.NUM_CELLS(NC), .DEPTH(8), .WINDOW(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .cell_valid(cell_valid), .cell_toa(cell_toa),
    .cell_tot(cell_tot), .trig_valid(trig_valid), .trig_tag(trig_tag),
    .cell_ack(cell_ack), .out_strobe(out_strobe), .out_hit(out_hit),
    .out_toa(out_toa), .out_tot(out_tot), .full(full)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push_pkt(input int c, input int toa, input int tot);
    @(negedge clk);
    cell_valid[c] = 1'b1;
    cell_toa[c]   = 8'(toa);
    cell_tot[c]   = 4'(tot);
    @(posedge clk);
    @(negedge clk);
    chk("R2 ack", int'(cell_ack[c]), 1);
    cell_valid[c] = 1'b0;
  endtask

  task automatic do_trig(input int tag, input int exp_hit, input int exp_tot, input int exp_toa);
    @(negedge clk);
    trig_valid = 1'b1;
    trig_tag   = 8'(tag);
    @(posedge clk);
    @(negedge clk);
    trig_valid = 1'b0;
    chk("R5 strobe", int'(out_strobe), 1);
    chk(exp_hit ? "R6 hit" : "R7 hit", int'(out_hit), exp_hit);
    chk(exp_hit ? "R6 tot" : "R7 tot", int'(out_tot), exp_tot);
    chk(exp_hit ? "R6 toa" : "R7 toa", int'(out_toa), exp_toa);
  endtask

  // {op(1)=push0/trig1, cell(2), toa(8), tot(4), exp_hit(1), exp_tot(4)}
  localparam logic [19:0] VEC [0:9] = '{
    {1'b0, 2'd0, 8'd10, 4'd3, 1'b0, 4'd0},
    {1'b0, 2'd1, 8'd12, 4'd5, 1'b0, 4'd0},
    {1'b0, 2'd2, 8'd10, 4'd7, 1'b0, 4'd0},
    {1'b0, 2'd3, 8'd20, 4'd9, 1'b0, 4'd0},
    {1'b1, 2'd0, 8'd10, 4'd0, 1'b1, 4'd3},  // R6 oldest of two
    {1'b1, 2'd0, 8'd10, 4'd0, 1'b1, 4'd7},  // R6 second one kept
    {1'b1, 2'd0, 8'd11, 4'd0, 1'b0, 4'd0},  // R7 miss, R8 ahead kept
    {1'b1, 2'd0, 8'd30, 4'd0, 1'b0, 4'd0},  // R8 drops 12 (age 18)
    {1'b1, 2'd0, 8'd20, 4'd0, 1'b1, 4'd9},  // R8 keeps 20 (age 10)
    {1'b1, 2'd0, 8'd12, 4'd0, 1'b0, 4'd0}   // R8 12 was discarded
  };

  initial begin
    rst_n      = 1'b0;
    cell_valid = '0;
    cell_toa   = '0;
    cell_tot   = '0;
    trig_valid = 1'b0;
    trig_tag   = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 ack in reset", int'(cell_ack), 0);
    chk("R1 strobe in reset", int'(out_strobe), 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1 ack", int'(cell_ack), 0);
    chk("R1 strobe", int'(out_strobe), 0);
    chk("R1 hit", int'(out_hit), 0);
    chk("R1 full", int'(full), 0);

    // Table walk
    for (int k = 0; k < 10; k++) begin
      if (VEC[k][19] == 1'b0)
        push_pkt(int'(VEC[k][18:17]), int'(VEC[k][16:9]), int'(VEC[k][8:5]));
      else
        do_trig(int'(VEC[k][16:9]), int'(VEC[k][4]), int'(VEC[k][3:0]),
                VEC[k][4] ? int'(VEC[k][16:9]) : 0);
    end

    // R3: four cells at once, lowest index first
    @(negedge clk);
    for (int c = 0; c < NC; c++) begin
      cell_valid[c] = 1'b1;
      cell_toa[c]   = 8'(40 + c);
      cell_tot[c]   = 4'(c);
    end
    for (int c = 0; c < NC; c++) begin
      @(posedge clk);
      @(negedge clk);
      chk("R3 grant order", int'(cell_ack), 1 << c);
      cell_valid[c] = 1'b0;
    end
    do_trig(43, 1, 3, 43);
    do_trig(41, 1, 1, 41);
    do_trig(40, 1, 0, 40);
    do_trig(42, 1, 2, 42);

    // R4: fill, then hold a cell off while full
    for (int i = 0; i < 8; i++) push_pkt(0, 50 + i, i);
    chk("R4 full at depth", int'(full), 1);
    @(negedge clk);
    cell_valid[1] = 1'b1;
    cell_toa[1]   = 8'd60;
    cell_tot[1]   = 4'd6;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk);
      @(negedge clk);
      chk("R4 no ack while full", int'(cell_ack), 0);
      chk("R4 full held", int'(full), 1);
    end
    trig_valid = 1'b1;
    trig_tag   = 8'd50;
    @(posedge clk);
    @(negedge clk);
    trig_valid = 1'b0;
    chk("R6 hit from full", int'(out_hit), 1);
    chk("R4 blocked at full edge", int'(cell_ack), 0);
    chk("R4 full drops", int'(full), 0);
    @(posedge clk);
    @(negedge clk);
    chk("R4 accepted after room", int'(cell_ack), 2);
    chk("R4 full again", int'(full), 1);
    cell_valid[1] = 1'b0;
    do_trig(57, 1, 7, 57);

    // R9: acceptance and trigger on the same edge; R8 drops 51..53
    @(negedge clk);
    cell_valid[2] = 1'b1;
    cell_toa[2]   = 8'd70;
    cell_tot[2]   = 4'd11;
    trig_valid    = 1'b1;
    trig_tag      = 8'd70;
    @(posedge clk);
    @(negedge clk);
    trig_valid    = 1'b0;
    cell_valid[2] = 1'b0;
    chk("R9 strobe", int'(out_strobe), 1);
    chk("R9 new packet not matched", int'(out_hit), 0);
    chk("R9 still acknowledged", int'(cell_ack), 4);
    chk("R9 not full", int'(full), 0);
    do_trig(70, 1, 11, 70);   // R9 found later
    do_trig(51, 0, 0, 0);     // R8 stale entry gone
    do_trig(54, 1, 4, 54);    // R8 age equal to window kept
    do_trig(60, 1, 6, 60);    // R8 survivor order intact

    @(negedge clk);
    chk("R5 strobe single cycle", int'(out_strobe), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 8);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule